// File: doc/BRIEF.md
# Word FIFO DMA Request Bridge

This block sits between a host processor and a DMA channel owned by a second processor. The host programs a transfer length, sets a transfer-enable bit and then writes 16-bit words, one at a time, into an eight-word FIFO. The FIFO drains only in groups of four words. It drains when the buffered word count reaches a multiple of four while the DMA channel is set to the FIFO-request mode and its master enable is on. It also drains when the DMA side requests a drain, provided the FIFO holds a nonzero multiple of four words.

During a drain the block presents each word, with its destination address, on a valid/ready write port, one word per clock. For each word accepted, the destination address moves up by two bytes, the DMA transfer count drops by one and the host length drops by one. At the end of a drain the FIFO is emptied and the full flag is cleared. If the host length has reached zero, the transfer-enable bit is dropped. If the DMA count has reached zero, the channel's transfer-end flag is raised.

The DMA side loads its count and destination address with a one-cycle load strobe. The host reads its status (enable, full, ROM-visibility) and its remaining length directly from output ports.

Top module: `dma_word_bridge`

## Requirements
- R1: A host write to the length register (select 1) stores the data with bits 1:0 forced to zero.
- R2: A host write to the FIFO data port (select 2) is dropped while the transfer-enable bit (status bit 0) is clear.
- R3: When the FIFO holds 8 words, the full bit (status bit 1) is set and further FIFO writes are dropped.
- R4: A host FIFO write that brings the word count to a multiple of four starts a drain only when the channel mode equals 2'b01 and the master enable is 1. Otherwise the words stay buffered.
- R5: Each word drained goes out at the current destination address. The address then rises by 2, the DMA count falls by 1 and the host length falls by 1, stopping at zero.
- R6: After a drain the FIFO is empty, any words not drained are discarded, and the full bit is clear. The transfer-enable bit is cleared if the host length is zero.
- R7: A drain stops as soon as the DMA count reaches zero, and at that point the transfer-end flag is set.
- R8: A host write to the control register (select 0) sets transfer-enable from data bit 0 and ROM-visibility (status bit 2) from data bit 2, and leaves the full bit unchanged.
- R9: A DMA-side drain request starts a drain only if the channel is configured (mode 2'b01, master enable 1) and the FIFO holds a nonzero multiple of four words.
- R10: A drain moves at most one word per clock and holds valid, address and data until ready is seen. Host writes of every kind are ignored while a drain is running.
- R11: A channel load strobe, when no drain is running, loads the DMA count and destination address and clears the transfer-end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select: 0 control, 1 length, 2 FIFO data |
| host_wdata | input | 16 | Host write data |
| host_status | output | 3 | Bit 0 transfer enable, bit 1 full, bit 2 ROM visibility |
| host_len | output | 16 | Remaining host transfer length in words |
| dma_mode | input | 2 | Channel mode field; 2'b01 selects FIFO-request transfers |
| dma_master_en | input | 1 | DMA master enable |
| dma_load | input | 1 | Load strobe for count and destination address |
| dma_cnt_in | input | 24 | Transfer count to load |
| dma_dst_in | input | 32 | Destination byte address to load |
| dma_kick | input | 1 | DMA-side drain request |
| dma_cnt | output | 24 | Current DMA transfer count |
| dma_dst | output | 32 | Current destination address |
| dma_end | output | 1 | Transfer-end flag |
| out_valid | output | 1 | Word write valid |
| out_ready | input | 1 | Word write accepted |
| out_addr | output | 32 | Word write address |
| out_data | output | 16 | Word write data |

## Verification
The bench writes three words and checks that no drain starts until the fourth word arrives. A design that drained on every word, or never checked the mode and master enable, would show output too early. It overfills the FIFO, and then toggles transfer-enable while the FIFO is full, to confirm that the ninth word and the full bit are both left alone. It loads a DMA count smaller than the buffered group, so the drain must stop early, raise the end flag and discard the leftover words; a design that kept those words would put stale data into the next drain. It holds ready low during a drain and writes from the host at the same time, which would show up as a lost or duplicated word, a wrong length, or a gap between accepted words.

// File: rtl/dwb_pkg.sv
// Shared definitions for the word FIFO DMA request bridge.
// Assumes a 2-bit host register select and a 3-bit host status vector.
package dwb_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_FIFO = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    localparam int ST_EN   = 0;   // transfer enable
    localparam int ST_FULL = 1;   // FIFO full
    localparam int ST_ROM  = 2;   // ROM visibility

    localparam logic [1:0] MODE_FIFO_REQ = 2'b01;

endpackage

// File: rtl/dwb_fifo.sv
// Word FIFO storage with an occupancy counter and full flag.
// Words are written at the occupancy index and read by an external
// index during a drain; a clear empties the whole FIFO at once.
// Assumes push and clear never occur in the same cycle.
module dwb_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              clear,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [PTR_W-1:0]  level,
    output logic              full,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] TOP  = PTR_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    // One write-enabled register per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && level == PTR_W'(g))
                mem[g] <= push_data;
        end
    end

    // Occupancy counter and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            full  <= 1'b0;
        end else if (clear) begin
            level <= '0;
            full  <= 1'b0;
        end else if (push) begin
            level <= level + 1'b1;
            if (level == LAST)
                full <= 1'b1;
        end
    end

    // Read port for the drain engine.
    always_comb begin
        rd_data = '0;
        if (rd_idx < TOP)
            rd_data = mem[rd_idx[IDX_W-1:0]];
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP);

    assert_full_blocks_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    assert_push_clear_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && clear));

endmodule

// File: rtl/dwb_host_regs.sv
// Host-side control and length registers.
// Control writes update only transfer enable and ROM visibility; length
// writes are forced to a whole group of words. The length counts down
// per drained word (stopping at zero) and the enable drops at the end of
// a drain that leaves the length at zero.
// Assumes writes are already gated off while a drain runs.
module dwb_host_regs #(
    parameter int DATA_W = 16,
    parameter int GB     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              len_dec,
    input  logic              drain_done,
    output logic              xfer_en,
    output logic              rom_vis,
    output logic [DATA_W-1:0] len
);

    import dwb_pkg::*;

    // Control bits: host writes, drain-end clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_en <= 1'b0;
            rom_vis <= 1'b0;
        end else if (wr_en && sel == SEL_CTRL) begin
            xfer_en <= wdata[ST_EN];
            rom_vis <= wdata[ST_ROM];
        end else if (drain_done && len == '0) begin
            xfer_en <= 1'b0;
        end
    end

    // Length register: aligned load, saturating countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len <= '0;
        else if (wr_en && sel == SEL_LEN)
            len <= {wdata[DATA_W-1:GB], {GB{1'b0}}};
        else if (len_dec && len != '0)
            len <= len - 1'b1;
    end

    assert_len_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LEN) |=> len[GB-1:0] == '0);

    assert_en_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_done && len == '0) |=> !xfer_en);

    assert_len_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (len_dec && len == '0) |=> len == '0);

endmodule

// File: rtl/dwb_drain.sv
// Drain engine: walks the FIFO from entry 0 and emits one word per
// accepted handshake at the destination address, stepping the address
// and DMA count. It stops when all buffered words are sent or the count
// hits zero, and raises the end flag in the latter case.
// Assumes start is only asserted while idle.
module dwb_drain #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  fifo_level,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cfg_load,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic              out_ready,
    output logic              busy,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              step,
    output logic              done,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt,
    output logic              end_flag
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    logic cnt_zero;
    logic all_sent;

    // Drain status decode.
    always_comb begin
        cnt_zero  = (cnt == '0);
        all_sent  = (rd_idx == fifo_level);
        done      = busy && (all_sent || cnt_zero);
        out_valid = busy && !all_sent && !cnt_zero;
        step      = out_valid && out_ready;
        out_addr  = dst;
        out_data  = rd_data;
    end

    // Busy flag and read index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            rd_idx <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            rd_idx <= '0;
        end else if (done) begin
            busy   <= 1'b0;
        end else if (step) begin
            rd_idx <= rd_idx + 1'b1;
        end
    end

    // Channel count and destination address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dst <= '0;
        end else if (cfg_load && !busy) begin
            cnt <= cnt_in;
            dst <= dst_in;
        end else if (step) begin
            cnt <= cnt - 1'b1;
            dst <= dst + WORD_BYTES;
        end
    end

    // Transfer-end flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            end_flag <= 1'b0;
        else if (cfg_load && !busy)
            end_flag <= 1'b0;
        else if (done && cnt_zero)
            end_flag <= 1'b1;
    end

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (dst == $past(dst) + WORD_BYTES) && (cnt == $past(cnt) - 1'b1));

    assert_end_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> cnt == '0);

    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_addr));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/dma_word_bridge.sv
// Top of the word FIFO DMA request bridge.
// Gates host writes, decides when a group of words may drain (host write
// completing a group, or a DMA-side request on a full group), and wires
// FIFO, host registers and drain engine together.
// Assumes GROUP is a power of two that divides DEPTH.
module dma_word_bridge #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int DEPTH  = 8,
    parameter int GROUP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [2:0]        host_status,
    output logic [DATA_W-1:0] host_len,
    input  logic [1:0]        dma_mode,
    input  logic              dma_master_en,
    input  logic              dma_load,
    input  logic [CNT_W-1:0]  dma_cnt_in,
    input  logic [ADDR_W-1:0] dma_dst_in,
    input  logic              dma_kick,
    output logic [CNT_W-1:0]  dma_cnt,
    output logic [ADDR_W-1:0] dma_dst,
    output logic              dma_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    import dwb_pkg::*;

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int GB    = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic              busy, step, done;
    logic              xfer_en, rom_vis, full;
    logic [PTR_W-1:0]  level, level_next, rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              host_ok, push, cfg_ok, host_trig, kick_trig, start;

    // Write gating and drain trigger decode.
    always_comb begin
        host_ok    = host_wr_en && !busy;
        push       = host_ok && host_sel == SEL_FIFO && xfer_en && !full;
        level_next = level + 1'b1;
        cfg_ok     = (dma_mode == MODE_FIFO_REQ) && dma_master_en;
        host_trig  = push && (level_next[GB-1:0] == '0);
        kick_trig  = dma_kick && (level != '0) && (level[GB-1:0] == '0);
        start      = !busy && cfg_ok && (host_trig || kick_trig);
    end

    dwb_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (host_wdata),
        .clear     (done),
        .rd_idx    (rd_idx),
        .level     (level),
        .full      (full),
        .rd_data   (rd_data)
    );

    dwb_host_regs #(
        .DATA_W (DATA_W),
        .GB     (GB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_ok),
        .sel        (host_sel),
        .wdata      (host_wdata),
        .len_dec    (step),
        .drain_done (done),
        .xfer_en    (xfer_en),
        .rom_vis    (rom_vis),
        .len        (host_len)
    );

    dwb_drain #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PTR_W  (PTR_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fifo_level (level),
        .rd_data    (rd_data),
        .cfg_load   (dma_load),
        .cnt_in     (dma_cnt_in),
        .dst_in     (dma_dst_in),
        .out_ready  (out_ready),
        .busy       (busy),
        .rd_idx     (rd_idx),
        .step       (step),
        .done       (done),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_data   (out_data),
        .dst        (dma_dst),
        .cnt        (dma_cnt),
        .end_flag   (dma_end)
    );

    // Host status vector.
    always_comb begin
        host_status          = '0;
        host_status[ST_EN]   = xfer_en;
        host_status[ST_FULL] = full;
        host_status[ST_ROM]  = rom_vis;
    end

    assert_ctrl_keeps_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ok && host_sel == SEL_CTRL) |=> full == $past(full));

    assert_start_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> cfg_ok);

    assert_busy_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push);

endmodule

// File: tb/tb_dma_word_bridge.sv
// Self-checking bench: a table of host register operations first, then
// directed drain scenarios checked through a capture monitor.
module tb_dma_word_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_sel = 2'd3;
    logic [15:0] host_wdata = '0;
    logic [2:0]  host_status;
    logic [15:0] host_len;
    logic [1:0]  dma_mode = 2'b00;
    logic        dma_master_en = 1'b0;
    logic        dma_load = 1'b0;
    logic [23:0] dma_cnt_in = '0;
    logic [31:0] dma_dst_in = '0;
    logic        dma_kick = 1'b0;
    logic [23:0] dma_cnt;
    logic [31:0] dma_dst;
    logic        dma_end;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [15:0] out_data;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int cap_n = 0;
    logic [31:0] cap_addr [64];
    logic [15:0] cap_data [64];
    int          cap_cyc  [64];

    always #5 clk = ~clk;

    dma_word_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_status(host_status), .host_len(host_len),
        .dma_mode(dma_mode), .dma_master_en(dma_master_en), .dma_load(dma_load),
        .dma_cnt_in(dma_cnt_in), .dma_dst_in(dma_dst_in), .dma_kick(dma_kick),
        .dma_cnt(dma_cnt), .dma_dst(dma_dst), .dma_end(dma_end),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data)
    );

    // Capture monitor and watchdog.
    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap_addr[cap_n] = out_addr;
            cap_data[cap_n] = out_data;
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
        cyc = cyc + 1;
        if (cyc == 100000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_sel   = sel;
        host_wdata = data;
        @(negedge clk);
        host_wr_en = 1'b0;
        host_sel   = 2'd3;
    endtask

    task automatic dma_cfg(input logic [23:0] c, input logic [31:0] d);
        @(negedge clk);
        dma_load   = 1'b1;
        dma_cnt_in = c;
        dma_dst_in = d;
        @(negedge clk);
        dma_load   = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        dma_kick = 1'b1;
        @(negedge clk);
        dma_kick = 1'b0;
    endtask

    // {op, data, expected status, expected length}; op 0 ctrl, 1 len, 2 fifo
    localparam int NV = 19;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 16'h0005, 3'b101, 16'h0000},
        {2'd1, 16'h0013, 3'b101, 16'h0010},
        {2'd1, 16'hFFFF, 3'b101, 16'hFFFC},
        {2'd0, 16'hFFFA, 3'b000, 16'hFFFC},
        {2'd2, 16'h1111, 3'b000, 16'hFFFC},
        {2'd0, 16'h0001, 3'b001, 16'hFFFC},
        {2'd1, 16'h0008, 3'b001, 16'h0008},
        {2'd2, 16'hA000, 3'b001, 16'h0008},
        {2'd2, 16'hA001, 3'b001, 16'h0008},
        {2'd2, 16'hA002, 3'b001, 16'h0008},
        {2'd2, 16'hA003, 3'b001, 16'h0008},
        {2'd2, 16'hA004, 3'b001, 16'h0008},
        {2'd2, 16'hA005, 3'b001, 16'h0008},
        {2'd2, 16'hA006, 3'b001, 16'h0008},
        {2'd2, 16'hA007, 3'b011, 16'h0008},
        {2'd2, 16'h9999, 3'b011, 16'h0008},
        {2'd0, 16'h0004, 3'b110, 16'h0008},
        {2'd0, 16'h0005, 3'b111, 16'h0008},
        {2'd1, 16'h0008, 3'b111, 16'h0008}
    };

    initial begin
        int base;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("reset status", 64'(host_status), 64'h0);
        chk("reset len", 64'(host_len), 64'h0);
        chk("reset valid", 64'(out_valid), 64'h0);
        chk("reset end", 64'(dma_end), 64'h0);
        chk("reset cnt", 64'(dma_cnt), 64'h0);

        // Table phase: channel unconfigured, so nothing drains
        for (int i = 0; i < NV; i++) begin
            string req;
            host_write(VEC[i][36:35], VEC[i][34:19]);
            case (VEC[i][36:35])
                2'd0:    req = "R8";
                2'd1:    req = "R1";
                default: req = (i == 4) ? "R2" : "R3";
            endcase
            chk({req, " table status"}, 64'(host_status), 64'(VEC[i][18:16]));
            chk({req, " table len"}, 64'(host_len), 64'(VEC[i][15:0]));
        end
        chk("R4 no drain unconfigured", 64'(cap_n), 64'd0);

        // R9: DMA-side request drains the full FIFO
        dma_mode = 2'b01;
        dma_master_en = 1'b1;
        dma_cfg(24'd16, 32'h0600_0000);
        chk("R11 load cnt", 64'(dma_cnt), 64'd16);
        kick();
        wait_cyc(12);
        chk("R9 kick drained eight", 64'(cap_n), 64'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R3 R5 drain data", 64'(cap_data[i]), 64'(16'hA000 + 16'(i)));
            chk("R5 drain addr", 64'(cap_addr[i]), 64'(32'h0600_0000 + 32'(2 * i)));
        end
        chk("R6 status after drain", 64'(host_status), 64'b100);
        chk("R5 len after drain", 64'(host_len), 64'd0);
        chk("R5 cnt after drain", 64'(dma_cnt), 64'd8);
        chk("R5 dst after drain", 64'(dma_dst), 64'h0600_0010);
        chk("R7 end still low", 64'(dma_end), 64'd0);

        // R4: host write completing a group starts the drain
        host_write(2'd0, 16'h0001);
        host_write(2'd1, 16'h0008);
        host_write(2'd2, 16'hB000);
        host_write(2'd2, 16'hB001);
        host_write(2'd2, 16'hB002);
        wait_cyc(3);
        chk("R4 no drain at three", 64'(cap_n), 64'd8);
        host_write(2'd2, 16'hB003);
        wait_cyc(8);
        chk("R4 group drained", 64'(cap_n), 64'd12);
        for (int i = 0; i < 4; i++) begin
            chk("R4 group data", 64'(cap_data[8 + i]), 64'(16'hB000 + 16'(i)));
            chk("R5 group addr", 64'(cap_addr[8 + i]), 64'(32'h0600_0010 + 32'(2 * i)));
        end
        chk("R6 enable kept len nonzero", 64'(host_status), 64'b001);
        chk("R5 len four", 64'(host_len), 64'd4);
        chk("R5 cnt four", 64'(dma_cnt), 64'd4);

        // R7: count runs out part way through a group
        dma_cfg(24'd2, 32'h0600_0100);
        for (int i = 0; i < 4; i++) host_write(2'd2, 16'hC000 + 16'(i));
        wait_cyc(8);
        chk("R7 early stop count", 64'(cap_n), 64'd14);
        chk("R7 first word", 64'(cap_data[12]), 64'hC000);
        chk("R7 second word", 64'(cap_data[13]), 64'hC001);
        chk("R7 end flag set", 64'(dma_end), 64'd1);
        chk("R7 cnt zero", 64'(dma_cnt), 64'd0);
        chk("R5 len two", 64'(host_len), 64'd2);
        chk("R6 status", 64'(host_status), 64'b001);

        // R11: load clears end flag
        dma_cfg(24'd4, 32'h0000_0100);
        chk("R11 end cleared", 64'(dma_end), 64'd0);
        chk("R11 cnt loaded", 64'(dma_cnt), 64'd4);
        chk("R11 dst loaded", 64'(dma_dst), 64'h100);

        // R4 / R9 negative cases then a good request
        dma_mode = 2'b10;
        for (int i = 0; i < 4; i++) host_write(2'd2, 16'hD000 + 16'(i));
        wait_cyc(4);
        chk("R4 wrong mode holds", 64'(cap_n), 64'd14);
        dma_mode = 2'b01;
        dma_master_en = 1'b0;
        kick();
        wait_cyc(4);
        chk("R9 master off holds", 64'(cap_n), 64'd14);
        dma_master_en = 1'b1;
        kick();
        wait_cyc(8);
        chk("R9 kick drained", 64'(cap_n), 64'd18);
        for (int i = 0; i < 4; i++) begin
            chk("R6 leftovers dropped data", 64'(cap_data[14 + i]), 64'(16'hD000 + 16'(i)));
            chk("R5 addr", 64'(cap_addr[14 + i]), 64'(32'h100 + 32'(2 * i)));
        end
        chk("R5 len stops at zero", 64'(host_len), 64'd0);
        chk("R6 enable cleared", 64'(host_status), 64'b000);
        chk("R7 end set", 64'(dma_end), 64'd1);
        kick();
        wait_cyc(4);
        chk("R9 empty kick ignored", 64'(cap_n), 64'd18);

        // R10: back-pressure and host writes during a drain
        dma_cfg(24'd8, 32'h0000_0200);
        host_write(2'd0, 16'h0001);
        host_write(2'd1, 16'h0004);
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) host_write(2'd2, 16'hE000 + 16'(i));
        wait_cyc(3);
        chk("R10 valid held", 64'(out_valid), 64'd1);
        chk("R10 data held", 64'(out_data), 64'hE000);
        chk("R10 addr held", 64'(out_addr), 64'h200);
        host_write(2'd2, 16'h7777);
        host_write(2'd1, 16'h0040);
        chk("R10 len write ignored", 64'(host_len), 64'd4);
        out_ready = 1'b1;
        wait_cyc(8);
        chk("R10 word count", 64'(cap_n), 64'd22);
        base = 18;
        for (int i = 0; i < 4; i++)
            chk("R10 data order", 64'(cap_data[base + i]), 64'(16'hE000 + 16'(i)));
        for (int i = 1; i < 4; i++)
            chk("R10 one per clock", 64'(cap_cyc[base + i] - cap_cyc[base + i - 1]), 64'd1);
        chk("R6 final status", 64'(host_status), 64'b000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule